// File: doc/BRIEF.md
# Fence and Acquire/Release Ordering Gate

This block controls issue between a core's in-order memory-operation stream and a memory system that may complete operations in any order. Each operation offered on the stream is a plain data access, a full fence, an acquire or a release. The gate keeps a count of operations sent to memory that have not yet completed. It holds the head of the stream until the ordering rule for that operation's kind is met.

A fence never reaches memory. It waits until nothing is outstanding, then finishes in the cycle it is accepted. Because the stream is in order, everything behind it stays blocked until then. A release also waits until nothing is outstanding, but it then goes to memory and younger operations may pass it at once. An acquire goes to memory without regard to older traffic, and it then blocks every younger operation until its own completion returns. Memory reports one completion per cycle together with the kind of operation that completed. The gate raises a done pulse with the ordering kind when a fence is accepted or when an acquire or release completes.

Top module: `ord_gate`

## Requirements
- R1: During and right after reset nothing is outstanding. No acquire is pending, `op_ready` is 1 for every kind, and `ord_done` and `mem_issue` are 0.
- R2: Kind encoding on `op_kind` and `cpl_kind` is 0 data, 1 fence, 2 acquire, 3 release. A data operation is accepted when nothing blocks it, and `mem_issue` is 1 in exactly the cycle in which a data, acquire or release operation is accepted.
- R3: The outstanding count is `CNT_W` bits wide (default 4, maximum 15). While it is at its maximum, no data, acquire or release operation is accepted. An accept and a completion in the same cycle leave the count unchanged.
- R4: A fence is accepted only in a cycle where the outstanding count is zero. It raises no `mem_issue`, and it raises `ord_done` with `ord_kind` = 1 in that same cycle.
- R5: While a fence waits at the head of the stream, `mem_issue` stays 0.
- R6: A release is accepted only when the outstanding count is zero, and this includes an earlier release that has not completed.
- R7: A data operation offered in the cycle after a release is accepted is itself accepted, without waiting for the release to complete.
- R8: An acquire is accepted while older data operations are still outstanding.
- R9: Once an acquire is accepted, no operation of any kind is accepted until the cycle after the acquire's completion.
- R10: A completion with `cpl_kind` 2 or 3 raises `ord_done` in that cycle, with `ord_kind` equal to `cpl_kind`. A data completion raises no `ord_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Head of the operation stream is present |
| op_kind | input | 2 | Kind of the head operation |
| op_ready | output | 1 | Head operation may be accepted this cycle |
| mem_issue | output | 1 | Accepted operation is sent to memory this cycle |
| cpl_valid | input | 1 | Memory reports one completion this cycle |
| cpl_kind | input | 2 | Kind of the completed operation |
| ord_done | output | 1 | An ordering operation finished this cycle |
| ord_kind | output | 2 | Kind of the ordering operation that finished |

## Verification
The corner that is hardest to reach from the ports is the full counter. The count only becomes visible through `op_ready`, so the stimulus first issues exactly fifteen data operations without any completions. It then retires one and offers an issue together with a completion in the same cycle. One further issue must still be accepted, and the next must be refused. A second difficult point is the release that stalls on its own predecessor. The stimulus accepts a release, lets a younger data operation slip past it, and then offers a second release while the first one is still in flight.

// File: rtl/ord_pkg.sv
package ord_pkg;

  typedef enum logic [1:0] {
    OP_DATA  = 2'd0,
    OP_FENCE = 2'd1,
    OP_ACQ   = 2'd2,
    OP_REL   = 2'd3
  } op_kind_e;

  // Operations that travel on to memory and occupy a counter slot
  function automatic logic goes_to_mem(op_kind_e k);
    return k != OP_FENCE;
  endfunction

  // Whether the head operation of a given kind may be accepted
  function automatic logic may_accept(op_kind_e k, logic empty, logic full,
                                      logic acq_wait);
    logic ok;
    ok = !acq_wait;
    unique case (k)
      OP_DATA:  ok = ok && !full;
      OP_FENCE: ok = ok && empty;
      OP_ACQ:   ok = ok && !full;
      OP_REL:   ok = ok && empty && !full;
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/ord_counter.sv
module ord_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             empty,
  output logic             full
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] step(logic [CNT_W-1:0] c, logic up,
                                            logic down);
    logic take;
    take = down && (c != '0);
    if (up && !take)      return c + 1'b1;
    else if (!up && take) return c - 1'b1;
    else                  return c;
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= step(cnt_q, inc, dec);
  end

  assign cnt   = cnt_q;
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_MAX);
endmodule

// File: rtl/ord_acq_track.sv
module ord_acq_track (
  input  logic clk,
  input  logic rst_n,
  input  logic acq_sent,
  input  logic acq_back,
  output logic acq_wait
);
  logic wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        wait_q <= 1'b0;
    else if (acq_sent) wait_q <= 1'b1;
    else if (acq_back) wait_q <= 1'b0;
  end

  assign acq_wait = wait_q;
endmodule

// File: rtl/ord_rules.sv
module ord_rules
  import ord_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       empty,
  input  logic       full,
  input  logic       acq_wait,
  output logic       ready,
  output logic       to_mem
);
  op_kind_e k;

  always_comb begin
    k      = op_kind_e'(kind);
    ready  = may_accept(k, empty, full, acq_wait);
    to_mem = goes_to_mem(k);
  end
endmodule

// File: rtl/ord_gate.sv
module ord_gate
  import ord_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [1:0] op_kind,
  output logic       op_ready,
  output logic       mem_issue,
  input  logic       cpl_valid,
  input  logic [1:0] cpl_kind,
  output logic       ord_done,
  output logic [1:0] ord_kind
);
  // Named internal events, visible to the bound checker
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_empty;
  logic             cnt_full;
  logic             acq_wait;
  logic             to_mem;
  logic             accept;
  logic             fence_fire;
  logic             acq_sent;
  logic             acq_back;
  logic             sync_back;

  ord_rules u_rules (
    .kind     (op_kind),
    .empty    (cnt_empty),
    .full     (cnt_full),
    .acq_wait (acq_wait),
    .ready    (op_ready),
    .to_mem   (to_mem)
  );

  assign accept     = op_valid && op_ready;
  assign mem_issue  = accept && to_mem;
  assign fence_fire = accept && (op_kind == OP_FENCE);
  assign acq_sent   = accept && (op_kind == OP_ACQ);
  assign acq_back   = cpl_valid && (cpl_kind == OP_ACQ);
  assign sync_back  = cpl_valid && (cpl_kind != OP_DATA);

  ord_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (mem_issue),
    .dec   (cpl_valid),
    .cnt   (cnt_q),
    .empty (cnt_empty),
    .full  (cnt_full)
  );

  ord_acq_track u_acq (
    .clk      (clk),
    .rst_n    (rst_n),
    .acq_sent (acq_sent),
    .acq_back (acq_back),
    .acq_wait (acq_wait)
  );

  assign ord_done = fence_fire || sync_back;
  assign ord_kind = fence_fire ? OP_FENCE : cpl_kind;
endmodule

// File: rtl/ord_gate_chk.sv
module ord_gate_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [1:0]       op_kind,
  input logic             op_ready,
  input logic             mem_issue,
  input logic             cpl_valid,
  input logic [CNT_W-1:0] cnt_q,
  input logic             acq_wait,
  input logic             fence_fire
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R3: no memory issue while the counter is saturated
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |-> !mem_issue);

  // R3: issue and completion together keep the count
  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_issue && cpl_valid && cnt_q != '0) |=> (cnt_q == $past(cnt_q)));

  // R4: a fence fires only on an empty counter and never goes to memory
  assert_fence_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fence_fire |-> (cnt_q == '0 && !mem_issue));

  // R5: a waiting fence lets nothing through
  assert_fence_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 2'd1 && !op_ready) |-> !mem_issue);

  // R6: a release leaves only on an empty counter
  assert_release_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_kind == 2'd3) |-> (cnt_q == '0));

  // R9: an accepted acquire blocks the stream from the next cycle
  assert_acq_arms_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_kind == 2'd2) |=> acq_wait);

  assert_acq_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acq_wait |-> !(op_valid && op_ready));
endmodule

bind ord_gate ord_gate_chk #(.CNT_W(CNT_W)) u_ord_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_kind    (op_kind),
  .op_ready   (op_ready),
  .mem_issue  (mem_issue),
  .cpl_valid  (cpl_valid),
  .cnt_q      (cnt_q),
  .acq_wait   (acq_wait),
  .fence_fire (fence_fire)
);

// File: tb/tb_ord_gate.sv
`timescale 1ns/1ps
module tb_ord_gate;
  localparam logic [1:0] K_DATA = 2'd0, K_FENCE = 2'd1, K_ACQ = 2'd2, K_REL = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [1:0] op_kind = 2'd0;
  logic       op_ready;
  logic       mem_issue;
  logic       cpl_valid = 1'b0;
  logic [1:0] cpl_kind = 2'd0;
  logic       ord_done;
  logic [1:0] ord_kind;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [1:0] exp_q[$];

  always #4 clk = ~clk;

  ord_gate dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_ready(op_ready), .mem_issue(mem_issue), .cpl_valid(cpl_valid),
    .cpl_kind(cpl_kind), .ord_done(ord_done), .ord_kind(ord_kind)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; expected done events go to the scoreboard
  task automatic step(input logic ov, input logic [1:0] k, input logic cv,
                      input logic [1:0] ck, input logic exp_rdy, input string tag);
    op_valid  = ov;
    op_kind   = k;
    cpl_valid = cv;
    cpl_kind  = ck;
    if (ov && exp_rdy && k == K_FENCE) exp_q.push_back(K_FENCE);
    if (cv && ck != K_DATA) exp_q.push_back(ck);
    @(negedge clk);
    if (ov) chk(op_ready, exp_rdy, {tag, " op_ready"});
    chk(mem_issue, ov && exp_rdy && k != K_FENCE, {tag, " mem_issue"});
    @(posedge clk);
    #1;
    op_valid  = 1'b0;
    cpl_valid = 1'b0;
  endtask

  // Monitor: compares done pulses against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (ord_done) begin
        if (exp_q.size() == 0) chk(1, 0, "R10 unexpected ord_done");
        else chk(ord_kind, exp_q.pop_front(), "R10 ord_kind");
      end else if (exp_q.size() != 0) begin
        chk(0, 1, "R10 missing ord_done");
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ord_done, 0, "R1 ord_done in reset");
    chk(mem_issue, 0, "R1 mem_issue in reset");
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(op_ready, 1, "R1 ready after reset");
    chk(ord_done, 0, "R1 no done after reset");
    @(posedge clk);
    #1;

    // R2 data issue, then R4/R5 fence waits on three outstanding
    for (int i = 0; i < 3; i++) step(1, K_DATA, 0, K_DATA, 1, "R2 data issue");
    step(1, K_FENCE, 0, K_DATA, 0, "R4 fence blocked");
    for (int i = 0; i < 3; i++) step(1, K_FENCE, 1, K_DATA, 0, "R5 fence waits");
    step(1, K_FENCE, 0, K_DATA, 1, "R4 fence on empty");

    // R8 acquire passes outstanding data, R9 blocks everything after it
    step(1, K_DATA, 0, K_DATA, 1, "R2 data issue");
    step(1, K_DATA, 0, K_DATA, 1, "R2 data issue");
    step(1, K_ACQ, 0, K_DATA, 1, "R8 acquire with data outstanding");
    step(1, K_DATA, 0, K_DATA, 0, "R9 data after acquire");
    step(1, K_REL, 0, K_DATA, 0, "R9 release after acquire");
    step(1, K_FENCE, 0, K_DATA, 0, "R9 fence after acquire");
    step(1, K_ACQ, 0, K_DATA, 0, "R9 acquire after acquire");
    step(1, K_DATA, 1, K_ACQ, 0, "R9 data in acquire completion cycle");
    step(1, K_DATA, 0, K_DATA, 1, "R9 data after acquire completion");

    // R6 release waits for empty; R7 younger data passes it
    step(1, K_REL, 0, K_DATA, 0, "R6 release with data outstanding");
    for (int i = 0; i < 3; i++) step(1, K_REL, 1, K_DATA, 0, "R6 release draining");
    step(1, K_REL, 0, K_DATA, 1, "R6 release on empty");
    step(1, K_DATA, 0, K_DATA, 1, "R7 data passes release");
    step(1, K_REL, 0, K_DATA, 0, "R6 release behind release");
    step(0, K_DATA, 1, K_REL, 0, "R10 release completion");
    step(0, K_DATA, 1, K_DATA, 0, "R10 data completion silent");
    step(1, K_FENCE, 0, K_DATA, 1, "R4 fence confirms empty");

    // R3 saturation and simultaneous issue/completion
    for (int i = 0; i < 15; i++) step(1, K_DATA, 0, K_DATA, 1, "R3 fill");
    step(1, K_DATA, 0, K_DATA, 0, "R3 data at max");
    step(1, K_ACQ, 0, K_DATA, 0, "R3 acquire at max");
    step(1, K_DATA, 1, K_DATA, 0, "R3 data at max with completion");
    step(1, K_DATA, 1, K_DATA, 1, "R3 issue and completion together");
    step(1, K_DATA, 0, K_DATA, 1, "R3 last free slot");
    step(1, K_DATA, 0, K_DATA, 0, "R3 full again");
    for (int i = 0; i < 14; i++) step(0, K_DATA, 1, K_DATA, 0, "R3 drain");
    step(1, K_FENCE, 0, K_DATA, 0, "R3 one still outstanding");
    step(0, K_DATA, 1, K_DATA, 0, "R3 drain last");
    step(1, K_FENCE, 0, K_DATA, 1, "R3 fence after drain");

    step(0, K_DATA, 0, K_DATA, 0, "R10 idle");
    chk(exp_q.size(), 0, "R10 scoreboard empty");
    finished = 1'b1;
    summary();
  end
endmodule